// File: doc/BRIEF.md
# USB Frame and Microframe Number Tracker

This block keeps the device-side view of USB bus timing. The token and CRC logic upstream reports each start-of-frame (SOF) through one of two strobes. One strobe marks a clean SOF and comes with its 11-bit frame number. The other marks an SOF that was seen but arrived corrupted. The tracker copies each clean frame number into its state. At high speed it also counts the eight 125 µs microframes that share one frame number.

Once the first clean SOF has arrived, the block treats SOFs as expected. If one arrives garbled, or none arrives within a timeout slightly longer than the nominal interval, the tracker creates a SOF of its own and advances its count. The frame number that software reads therefore stays continuous. The state is presented as read-only byte registers: a frame-number high byte, a frame-number low byte and a microframe index. A fourth byte packs the host-assigned device address together with the negotiated speed.

Top module: `usb_frame_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it falls, every output byte reads 0x00.
- R2: `frame_hi_o` carries frame bits 10..8 in its bits 2..0 with bits 7..3 at zero; `frame_lo_o` carries frame bits 7..0.
- R3: A clean SOF (`sof_ok`=1) puts `sof_fn` into the frame registers one cycle later, for every 11-bit value.
- R4: At full speed, a synthesized SOF adds one to the frame number, and 2047 wraps to 0.
- R5: Once locked, a synthesized SOF fires when no SOF has occurred for FS_TMO cycles (full speed) or HS_TMO cycles (high speed) since the last clean or synthesized SOF. A garbled strobe (`sof_bad`=1) also fires one at once, and every SOF restarts the wait.
- R6: At high speed, a clean SOF whose number equals the stored number advances the microframe index modulo 8. A clean SOF with a different number, or the first one after reset, sets the index to 0.
- R7: At high speed, a synthesized SOF advances the microframe index. When the index goes from 7 to 0, the frame number also increments, with wrap.
- R8: While `hs_link` is 0, the microframe register reads 0 from the next cycle on.
- R9: Before the first clean SOF after reset, garbled strobes and elapsed time change nothing.
- R10: `fnaddr_o` is registered: bit 7 is `hs_link` and bits 6..0 are `dev_addr`, both from the previous cycle.
- R11: When `sof_ok` and `sof_bad` are high in the same cycle, the clean frame number is taken and no synthesized SOF occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_ok | input | 1 | Clean SOF strobe, one cycle |
| sof_bad | input | 1 | Garbled SOF strobe, one cycle |
| sof_fn | input | 11 | Frame number carried by the clean SOF |
| hs_link | input | 1 | 1 when the link runs at high speed |
| dev_addr | input | 7 | Device address assigned by the host |
| frame_hi_o | output | 8 | Frame number high byte |
| frame_lo_o | output | 8 | Frame number low byte |
| ufrm_o | output | 8 | Microframe index, bits 2..0 |
| fnaddr_o | output | 8 | Speed flag and device address |

## Verification
Every one of the 2048 frame numbers is delivered as a clean SOF at full speed. This sweep separates a correct latch and byte split from stuck or misplaced bits. Runs of equal-number SOFs at high speed, followed by a changed number, separate index advance from index reset and show the modulo-8 wrap. The timeout and garbled paths are tried separately at both speeds, and also before lock. This separates the full-speed increment, the high-speed carry from microframe into frame, the 2047-to-0 wrap, and the lockout before the first clean SOF. The address byte is swept over all 128 addresses at both speed settings.

// File: rtl/frame_trk_pkg.sv
package frame_trk_pkg;
  localparam int FN_W   = 11;
  localparam int UF_W   = 3;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic            locked;
    logic [FN_W-1:0] fn;
    logic [UF_W-1:0] uf;
  } trk_state_t;
endpackage

// File: rtl/sof_watchdog.sv
module sof_watchdog #(
  parameter int FS_TMO = 61000,
  parameter int HS_TMO = 7700
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic hs,
  input  logic reload,
  output logic expire
);
  localparam int MAXT  = (FS_TMO > HS_TMO) ? FS_TMO : HS_TMO;
  localparam int CNT_W = $clog2(MAXT + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim    = hs ? CNT_W'(HS_TMO - 1) : CNT_W'(FS_TMO - 1);
  assign expire = arm && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || reload || !arm) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // R5
  reload_after_expire_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt == '0));
endmodule

// File: rtl/ufrm_seq.sv
module ufrm_seq
  import frame_trk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            sof_ok,
  input  logic            sof_bad,
  input  logic [FN_W-1:0] sof_fn,
  input  logic            hs,
  input  logic            expire,
  output logic            locked,
  output logic            sof_any,
  output logic [FN_W-1:0] fn_q,
  output logic [UF_W-1:0] uf_q
);
  trk_state_t st, st_nx;
  logic synth;

  assign synth   = st.locked && !sof_ok && (sof_bad || expire);
  assign sof_any = sof_ok || synth;

  always_comb begin
    st_nx = st;
    if (sof_ok) begin
      st_nx.locked = 1'b1;
      st_nx.fn     = sof_fn;
      if (hs && st.locked && (sof_fn == st.fn)) st_nx.uf = st.uf + 1'b1;
      else                                      st_nx.uf = '0;
    end else if (synth) begin
      if (hs) begin
        st_nx.uf = st.uf + 1'b1;
        if (&st.uf) st_nx.fn = st.fn + 1'b1;
      end else begin
        st_nx.fn = st.fn + 1'b1;
      end
    end
    if (!hs) st_nx.uf = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= st_nx;
  end

  assign locked = st.locked;
  assign fn_q   = st.fn;
  assign uf_q   = st.uf;

  // R3
  clean_latch_chk: assert property (@(posedge clk) disable iff (rst)
    sof_ok |=> (fn_q == $past(sof_fn)));
  // R4
  fs_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && !sof_ok && sof_bad && !hs) |=> (fn_q == FN_W'($past(fn_q) + 1'b1)));
  // R6
  hs_same_fn_chk: assert property (@(posedge clk) disable iff (rst)
    (sof_ok && hs && locked && (sof_fn == fn_q)) |=> (uf_q == UF_W'($past(uf_q) + 1'b1)));
  // R8
  fs_uf_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !hs |=> (uf_q == '0));
  // R9
  unlocked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!locked && !sof_ok) |=> ($stable(fn_q) && !locked));
  // R11
  clean_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (sof_ok && sof_bad) |=> (fn_q == $past(sof_fn)));
endmodule

// File: rtl/usb_frame_tracker.sv
module usb_frame_tracker
  import frame_trk_pkg::*;
#(
  parameter int FS_TMO = 61000,
  parameter int HS_TMO = 7700
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_ok,
  input  logic              sof_bad,
  input  logic [FN_W-1:0]   sof_fn,
  input  logic              hs_link,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic [BYTE_W-1:0] frame_hi_o,
  output logic [BYTE_W-1:0] frame_lo_o,
  output logic [BYTE_W-1:0] ufrm_o,
  output logic [BYTE_W-1:0] fnaddr_o
);
  localparam int HI_W = FN_W - BYTE_W;

  logic            locked, sof_any, expire;
  logic [FN_W-1:0] fn_q;
  logic [UF_W-1:0] uf_q;
  logic [BYTE_W-1:0] addr_q;

  sof_watchdog #(.FS_TMO(FS_TMO), .HS_TMO(HS_TMO)) u_wd (
    .clk(clk), .rst(rst), .arm(locked), .hs(hs_link),
    .reload(sof_any), .expire(expire)
  );

  ufrm_seq u_seq (
    .clk(clk), .rst(rst), .sof_ok(sof_ok), .sof_bad(sof_bad),
    .sof_fn(sof_fn), .hs(hs_link), .expire(expire),
    .locked(locked), .sof_any(sof_any), .fn_q(fn_q), .uf_q(uf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= {hs_link, dev_addr};
  end

  assign frame_hi_o = {{(BYTE_W-HI_W){1'b0}}, fn_q[FN_W-1:BYTE_W]};
  assign frame_lo_o = fn_q[BYTE_W-1:0];
  assign ufrm_o     = {{(BYTE_W-UF_W){1'b0}}, uf_q};
  assign fnaddr_o   = addr_q;

  // R10
  addr_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fnaddr_o == {$past(hs_link), $past(dev_addr)}));
  // R2
  hi_pad_chk: assert property (@(posedge clk) disable iff (rst)
    frame_hi_o[BYTE_W-1:HI_W] == '0);
endmodule

// File: tb/usb_frame_tracker_test.sv
module usb_frame_tracker_test;
  localparam int CLK_PER = 10;
  localparam int FS_T = 20;
  localparam int HS_T = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sof_ok = 1'b0, sof_bad = 1'b0, hs_link = 1'b0;
  logic [10:0] sof_fn = '0;
  logic [6:0]  dev_addr = '0;
  logic [7:0]  frame_hi_o, frame_lo_o, ufrm_o, fnaddr_o;

  int n_chk = 0, n_bad = 0;
  bit chk_en = 1'b0;
  string tag = "R1";

  // reference state
  logic        m_lk = 0;
  logic [10:0] m_fn = 0;
  logic [2:0]  m_uf = 0;
  logic [7:0]  m_ad = 0;
  int          m_cnt = 0;

  usb_frame_tracker #(.FS_TMO(FS_T), .HS_TMO(HS_T)) uut (
    .clk(clk), .rst(rst), .sof_ok(sof_ok), .sof_bad(sof_bad), .sof_fn(sof_fn),
    .hs_link(hs_link), .dev_addr(dev_addr), .frame_hi_o(frame_hi_o),
    .frame_lo_o(frame_lo_o), .ufrm_o(ufrm_o), .fnaddr_o(fnaddr_o)
  );

  always #(CLK_PER/2) clk = ~clk;

  task automatic check(string t, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", t, got, exp, $time);
    end
  endtask

  // reference model from the requirements
  always @(posedge clk) begin
    bit syn;
    int lim;
    if (rst) begin
      m_lk <= 0; m_fn <= 0; m_uf <= 0; m_ad <= 0; m_cnt <= 0;
    end else begin
      lim = hs_link ? HS_T : FS_T;
      syn = m_lk && !sof_ok && (sof_bad || (m_cnt >= lim - 1));
      m_ad <= {hs_link, dev_addr};
      if (sof_ok || syn || !m_lk) m_cnt <= 0; else m_cnt <= m_cnt + 1;
      if (sof_ok) begin
        m_lk <= 1;
        m_fn <= sof_fn;
        m_uf <= (hs_link && m_lk && sof_fn == m_fn) ? m_uf + 3'd1 : 3'd0;
      end else if (syn) begin
        if (hs_link) begin
          m_uf <= m_uf + 3'd1;
          if (m_uf == 3'd7) m_fn <= m_fn + 11'd1;
        end else m_fn <= m_fn + 11'd1;
      end
      if (!hs_link) m_uf <= 0;
    end
  end

  // per-cycle compare, away from the edge
  always @(posedge clk) begin
    #2;
    if (chk_en) begin
      check(tag, {21'd0, frame_hi_o[2:0], frame_lo_o}, {21'd0, m_fn});
      check("R2", {24'd0, frame_hi_o}, {29'd0, m_fn[10:8]});
      check(tag, {24'd0, ufrm_o}, {29'd0, m_uf});
      check("R10", {24'd0, fnaddr_o}, {24'd0, m_ad});
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sof(logic [10:0] f, logic bad);
    @(negedge clk); sof_ok = 1; sof_fn = f; sof_bad = bad;
    @(negedge clk); sof_ok = 0; sof_bad = 0;
  endtask

  task automatic garble;
    @(negedge clk); sof_bad = 1;
    @(negedge clk); sof_bad = 0;
  endtask

  initial begin
    #(CLK_PER * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    check("R1", {frame_hi_o, frame_lo_o, ufrm_o, fnaddr_o}, 32'd0);
    @(negedge clk); rst = 0;
    #3;
    check("R1", {frame_hi_o, frame_lo_o, ufrm_o, fnaddr_o}, 32'd0);
    chk_en = 1;
    // R9: no lock yet, garbles and time ignored
    tag = "R9";
    garble(); idle(3 * FS_T); garble(); idle(5);
    check("R9", {21'd0, frame_hi_o[2:0], frame_lo_o}, 32'd0);
    // R3: full sweep of frame numbers at full speed
    tag = "R3";
    for (int f = 0; f < 2048; f++) sof(11'(f), 1'b0);
    // R4: wrap via garbled strobes
    tag = "R4";
    sof(11'd2045, 1'b0);
    for (int i = 0; i < 4; i++) garble();
    #3 check("R4", {21'd0, frame_hi_o[2:0], frame_lo_o}, 32'd1);
    // R5: timeouts at full speed
    tag = "R5";
    sof(11'd2046, 1'b0);
    idle(5 * FS_T);
    garble(); idle(FS_T / 2); garble(); idle(2 * FS_T);
    // R11: clean and garbled together
    tag = "R11";
    sof(11'd700, 1'b1); idle(2);
    sof(11'd33, 1'b1);
    #3 check("R11", {24'd0, frame_lo_o}, 32'd33);
    // R6: high-speed series
    tag = "R6";
    @(negedge clk); hs_link = 1;
    for (int i = 0; i < 10; i++) sof(11'd100, 1'b0);
    #3 check("R6", {24'd0, ufrm_o}, 32'd1);
    sof(11'd101, 1'b0);
    for (int i = 0; i < 3; i++) sof(11'd101, 1'b0);
    // R7: high-speed synthesis with carry and wrap
    tag = "R7";
    idle(20 * HS_T);
    for (int i = 0; i < 9; i++) garble();
    sof(11'd2047, 1'b0);
    for (int i = 0; i < 8; i++) garble();
    #3 check("R7", {21'd0, frame_hi_o[2:0], frame_lo_o}, 32'd0);
    idle(3 * HS_T);
    // R8: drop to full speed with nonzero index
    tag = "R8";
    sof(11'd5, 1'b0); sof(11'd5, 1'b0); sof(11'd5, 1'b0);
    @(negedge clk); hs_link = 0;
    @(negedge clk);
    check("R8", {24'd0, ufrm_o}, 32'd0);
    idle(2 * FS_T);
    // R10: address sweep at both speeds
    tag = "R10";
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 128; a++) begin
        @(negedge clk); hs_link = s[0]; dev_addr = 7'(a);
      end
    idle(3);
    chk_en = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule